// File: doc/BRIEF.md
# Gated Serial Pulse Output Sequencer

This block sequences the pulses for a group of counter-driven serial output channels, such as a telemetry downlink or an altimeter feed. Each channel has its own enable bit written by software, its own destination select, and its own flags. All channels share two timing inputs: a gate-set strobe and a periodic timing pulse.

Setting the enable bit only arms the channel. The next gate-set strobe activates it. The first timing pulse after that sends one sync "1" pulse to one of two output pin pairs, chosen by the select bit at that moment, and clears the enable flip-flop. Each later timing pulse sends a shift request to the channel's output counter. A second gate-set strobe ends the sequence. While the channel is active, the enable readback still shows 1, because it is the OR of the enable flip-flop and the active flip-flop.

Top module: `pulse_seq_top`

## Requirements
- R1: After reset every channel is inactive and not armed. All sync, shift and readback outputs are 0.
- R2: Writing 1 to a channel's enable bit (enWrValid high, enWrData high) makes its readback 1 from the next cycle. Timing pulses then produce no sync and no shift until a gate-set strobe arrives.
- R3: A gate-set strobe on an armed, inactive channel activates it. The next timing pulse produces exactly one sync pulse and no shift request.
- R4: Every timing pulse after the sync pulse, while the channel stays active, produces one shift request and no sync pulse.
- R5: A gate-set strobe on an active channel makes it inactive and clears its enable bit, so the readback becomes 0. Later timing pulses and gate-set strobes produce nothing until enable is written again.
- R6: The sync pulse clears the enable flip-flop, but the readback stays 1 for as long as the channel is active.
- R7: The sync pulse goes to syncOnePri when destSel is 0 and to syncOneAlt when destSel is 1. The select is sampled in the cycle of the timing pulse itself, so a change made after activation takes effect.
- R8: When gate-set and a timing pulse arrive in the same cycle, gate-set is applied first. On an armed channel the sync pulse comes in that same cycle. On an active channel the sequence ends and no pulse is produced.
- R9: Each output pulse is registered. It is high only in the cycle after the clock edge that sampled the timing pulse, for exactly one cycle.
- R10: A software enable write in the same cycle as an internal clear of the enable flip-flop takes precedence. For example, a write of 1 together with a stopping gate-set leaves the channel inactive but armed.
- R11: Channels are independent. Activity on one channel never produces outputs on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gateSet | input | 1 | Shared gate-set strobe, used to start or stop a sequence |
| tickPulse | input | 1 | Shared timing pulse |
| enWrValid | input | NUM_CHAN | Per-channel strobe to write the enable bit |
| enWrData | input | NUM_CHAN | Value written to the enable bit |
| destSel | input | NUM_CHAN | Destination select: 0 for the primary pin pair, 1 for the alternate pin pair |
| syncOnePri | output | NUM_CHAN | Sync "1" pulse to the primary pin pair |
| syncOneAlt | output | NUM_CHAN | Sync "1" pulse to the alternate pin pair |
| shiftReq | output | NUM_CHAN | Shift request to the channel's output counter |
| enableRd | output | NUM_CHAN | Enable readback: enable flip-flop OR active flip-flop |

## Verification
The bench checks several corner cases:
- An armed channel must stay silent through timing pulses before gate-set. A design that started on the enable write would emit early pulses.
- Coincident gate-set and timing pulses must be ordered. A design that applied the timing pulse first would lose the sync pulse on start, or emit a stray shift request on stop.
- The select is changed between activation and the first timing pulse. A design that latched it at gate-set would send the sync pulse to the wrong pin pair.
- An enable write in the same cycle as a stopping gate-set must leave the channel armed. A design that gave the clear priority would fail to restart on the next gate-set.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  // Per-channel strobes handed from control to datapath
  typedef struct packed {
    logic syncNow;   // emit the sync "1" pulse this tick
    logic shiftNow;  // emit a shift request this tick
  } seqStrobe_t;
endpackage

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl
  import pulse_seq_pkg::*;
#(
  parameter int NUM_CHAN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gateSet,
  input  logic                tickPulse,
  input  logic [NUM_CHAN-1:0] enWrValid,
  input  logic [NUM_CHAN-1:0] enWrData,
  output seqStrobe_t [NUM_CHAN-1:0] strobes,
  output logic [NUM_CHAN-1:0] enableRd
);

  logic [NUM_CHAN-1:0] enFlag, activeFlag, startFlag;

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    logic actMid, startMid, enMid;
    logic syncNow, shiftNow;
    logic actNext, startNext, enNext;

    // Gate-set is resolved first, then the timing pulse acts on the result
    always_comb begin
      actMid   = activeFlag[i];
      startMid = startFlag[i];
      enMid    = enFlag[i];
      if (gateSet) begin
        if (activeFlag[i]) begin
          actMid   = 1'b0;
          startMid = 1'b0;
          enMid    = 1'b0;
        end else if (enFlag[i]) begin
          actMid   = 1'b1;
          startMid = 1'b1;
        end
      end
      syncNow   = tickPulse & actMid & startMid;
      shiftNow  = tickPulse & actMid & ~startMid;
      actNext   = actMid;
      startNext = startMid & ~syncNow;
      enNext    = syncNow ? 1'b0 : enMid;
      if (enWrValid[i]) enNext = enWrData[i];  // software write wins
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        activeFlag[i] <= 1'b0;
        startFlag[i]  <= 1'b0;
        enFlag[i]     <= 1'b0;
      end else begin
        activeFlag[i] <= actNext;
        startFlag[i]  <= startNext;
        enFlag[i]     <= enNext;
      end
    end

    assign strobes[i].syncNow  = syncNow;
    assign strobes[i].shiftNow = shiftNow;
    assign enableRd[i]         = enFlag[i] | activeFlag[i];

    assert_start_within_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      startFlag[i] |-> activeFlag[i]);

    assert_only_gate_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!activeFlag[i] && !gateSet) |=> !activeFlag[i]);

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gateSet && activeFlag[i] && !enWrValid[i]) |=> (!activeFlag[i] && !enFlag[i]));

    assert_sync_clears_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes[i].syncNow && !enWrValid[i]) |=> (!enFlag[i] && activeFlag[i]));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      enWrValid[i] |=> (enFlag[i] == $past(enWrData[i])));
  end

endmodule

// File: rtl/pulse_seq_datapath.sv
module pulse_seq_datapath
  import pulse_seq_pkg::*;
#(
  parameter int NUM_CHAN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seqStrobe_t [NUM_CHAN-1:0] strobes,
  input  logic [NUM_CHAN-1:0] destSel,
  output logic [NUM_CHAN-1:0] syncOnePri,
  output logic [NUM_CHAN-1:0] syncOneAlt,
  output logic [NUM_CHAN-1:0] shiftReq
);

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_route
    // Select is sampled on every pulse, never latched
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        syncOnePri[i] <= 1'b0;
        syncOneAlt[i] <= 1'b0;
        shiftReq[i]   <= 1'b0;
      end else begin
        syncOnePri[i] <= strobes[i].syncNow & ~destSel[i];
        syncOneAlt[i] <= strobes[i].syncNow &  destSel[i];
        shiftReq[i]   <= strobes[i].shiftNow;
      end
    end

    assert_one_dest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({syncOnePri[i], syncOneAlt[i], shiftReq[i]}));

    assert_dest_follows_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      syncOneAlt[i] |-> $past(destSel[i]));
  end

endmodule

// File: rtl/pulse_seq_top.sv
module pulse_seq_top
  import pulse_seq_pkg::*;
#(
  parameter int NUM_CHAN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gateSet,
  input  logic                tickPulse,
  input  logic [NUM_CHAN-1:0] enWrValid,
  input  logic [NUM_CHAN-1:0] enWrData,
  input  logic [NUM_CHAN-1:0] destSel,
  output logic [NUM_CHAN-1:0] syncOnePri,
  output logic [NUM_CHAN-1:0] syncOneAlt,
  output logic [NUM_CHAN-1:0] shiftReq,
  output logic [NUM_CHAN-1:0] enableRd
);

  seqStrobe_t [NUM_CHAN-1:0] strobes;

  pulse_seq_ctrl #(.NUM_CHAN(NUM_CHAN)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gateSet   (gateSet),
    .tickPulse (tickPulse),
    .enWrValid (enWrValid),
    .enWrData  (enWrData),
    .strobes   (strobes),
    .enableRd  (enableRd)
  );

  pulse_seq_datapath #(.NUM_CHAN(NUM_CHAN)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .destSel    (destSel),
    .syncOnePri (syncOnePri),
    .syncOneAlt (syncOneAlt),
    .shiftReq   (shiftReq)
  );

  assert_pulse_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(syncOnePri | syncOneAlt | shiftReq)) |-> $past(tickPulse));

endmodule

// File: tb/pulse_seq_tb.sv
module pulse_seq_top_tb_top;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic gateSet, tickPulse;
  logic [N-1:0] enWrValid, enWrData, destSel;
  logic [N-1:0] syncOnePri, syncOneAlt, shiftReq, enableRd;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pulse_seq_top #(.NUM_CHAN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .gateSet(gateSet), .tickPulse(tickPulse),
    .enWrValid(enWrValid), .enWrData(enWrData), .destSel(destSel),
    .syncOnePri(syncOnePri), .syncOneAlt(syncOneAlt),
    .shiftReq(shiftReq), .enableRd(enableRd)
  );

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic [N-1:0] pri,
                           input logic [N-1:0] alt, input logic [N-1:0] sh);
    check(req, "syncOnePri", syncOnePri, pri);
    check(req, "syncOneAlt", syncOneAlt, alt);
    check(req, "shiftReq", shiftReq, sh);
  endtask

  task automatic writeEn(input logic [N-1:0] mask, input logic [N-1:0] val);
    enWrValid = mask; enWrData = val;
    @(negedge clk);
    enWrValid = '0; enWrData = '0;
  endtask

  task automatic doGate();
    gateSet = 1'b1;
    @(negedge clk);
    gateSet = 1'b0;
  endtask

  task automatic doTick();
    tickPulse = 1'b1;
    @(negedge clk);
    tickPulse = 1'b0;
  endtask

  task automatic test_reset();
    checkOuts("R1", '0, '0, '0);
    check("R1", "enableRd", enableRd, '0);
  endtask

  task automatic test_armed_waits();
    writeEn(2'b01, 2'b01);
    check("R2", "enableRd armed", enableRd, 2'b01);
    doTick();
    checkOuts("R2", '0, '0, '0);
  endtask

  task automatic test_start_sync();
    destSel = 2'b00;
    doGate();
    doTick();
    checkOuts("R3", 2'b01, '0, '0);
    @(negedge clk);
    checkOuts("R9", '0, '0, '0);
    check("R6", "enableRd active", enableRd, 2'b01);
  endtask

  task automatic test_shift();
    for (int k = 0; k < 3; k++) begin
      doTick();
      checkOuts("R4", '0, '0, 2'b01);
      @(negedge clk);
      check("R9", "shiftReq drop", shiftReq, '0);
      check("R6", "enableRd during shift", enableRd, 2'b01);
    end
  endtask

  task automatic test_stop();
    doGate();
    check("R5", "enableRd after stop", enableRd, '0);
    doTick();
    checkOuts("R5", '0, '0, '0);
    doGate();
    doTick();
    checkOuts("R5", '0, '0, '0);
    check("R5", "enableRd stays off", enableRd, '0);
  endtask

  task automatic test_select();
    writeEn(2'b01, 2'b01);
    destSel = 2'b00;
    doGate();
    destSel = 2'b01;
    doTick();
    checkOuts("R7", '0, 2'b01, '0);
    doTick();
    checkOuts("R7", '0, '0, 2'b01);
    doGate();
    destSel = 2'b00;
  endtask

  task automatic test_same_cycle();
    writeEn(2'b01, 2'b01);
    gateSet = 1'b1; tickPulse = 1'b1;
    @(negedge clk);
    gateSet = 1'b0; tickPulse = 1'b0;
    checkOuts("R8", 2'b01, '0, '0);
    doTick();
    checkOuts("R8", '0, '0, 2'b01);
    gateSet = 1'b1; tickPulse = 1'b1;
    @(negedge clk);
    gateSet = 1'b0; tickPulse = 1'b0;
    checkOuts("R8", '0, '0, '0);
    check("R8", "enableRd after coincident stop", enableRd, '0);
  endtask

  task automatic test_write_wins();
    writeEn(2'b01, 2'b01);
    doGate();
    doTick();
    checkOuts("R10", 2'b01, '0, '0);
    gateSet = 1'b1; enWrValid = 2'b01; enWrData = 2'b01;
    @(negedge clk);
    gateSet = 1'b0; enWrValid = '0; enWrData = '0;
    check("R10", "enableRd re-armed", enableRd, 2'b01);
    doTick();
    checkOuts("R10", '0, '0, '0);
    doGate();
    doTick();
    checkOuts("R10", 2'b01, '0, '0);
    doGate();
  endtask

  task automatic test_independent();
    writeEn(2'b10, 2'b10);
    destSel = 2'b10;
    doGate();
    doTick();
    checkOuts("R11", '0, 2'b10, '0);
    check("R11", "enableRd", enableRd, 2'b10);
    doTick();
    checkOuts("R11", '0, '0, 2'b10);
    doGate();
    check("R11", "enableRd after stop", enableRd, '0);
  endtask

  initial begin
    rst_n = 1'b0; gateSet = 1'b0; tickPulse = 1'b0;
    enWrValid = '0; enWrData = '0; destSel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_armed_waits();
    test_start_sync();
    test_shift();
    test_stop();
    test_select();
    test_same_cycle();
    test_write_wins();
    test_independent();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule